// File: doc/BRIEF.md
# Fifteen-Level Prioritized Interrupt Controller

This block gathers interrupt requests from peripherals on levels 1 through 15 and drives a single 4-bit request level toward a processor core. The level it shows is the highest-numbered source that is active and not masked, and a value of zero means that nothing is requesting. Peripherals signal an event with a one-cycle pulse on their own request line. The core reports the level it is servicing on an acknowledge port, and that acknowledge retires the event.

Software controls the block through a small register port with a 3-bit select. It can read the pending set, set a mask, clear pending events, and turn on a test mode. In test mode a force register drives the request logic in addition to the pending register, so the whole interrupt path can be exercised without any peripheral activity. Writes that set bits with no meaning raise a one-cycle register-error pulse. The highest level cannot be masked.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on `irq_req[n]` (n from 1 to 15) sets pending bit n at the next clock edge. A pulse on `irq_req[0]` has no effect. Pending bit 0 always reads 0. The pending register is read with select 0.
- R2: Force bits take part in the request only while the test bit is 1. The test bit is bit 19 of the test-control register, at select 4. When the test bit is 0, forced bits are ignored but keep their value.
- R3: `irq_level` shows the highest set bit of (pending OR active force) AND NOT mask, over bits 15..1. It shows 0 when no such bit is set.
- R4: A write to the mask register (select 1) stores wdata AND 0x7FFE. Bit 15 of the mask is therefore always 0, and level 15 can never be masked.
- R5: A write to the clear port (select 2) clears every pending bit whose wdata bit is 1, over bits 15..1. The clear port reads as 0.
- R6: A write to the force register (select 3) stores wdata AND 0xFFFE, but only while the test bit is 1. At any other time the write leaves the force register unchanged.
- R7: An acknowledge of level n (n from 1 to 15) clears force bit n if the test bit is 1 and force bit n is set. In every other case it clears pending bit n. An acknowledge of level 0 changes nothing.
- R8: `reg_err` is high for exactly the cycle after either of these writes: a mask write with any bit of 0xFFFF8001 set, or a clear or force write with any bit of 0xFFFF0001 set. It stays low after any other write.
- R9: When a request pulse and a clear write or acknowledge hit the same pending bit in the same cycle, the bit stays set. When a force write and a force-clearing acknowledge happen in the same cycle, the written value is stored.
- R10: After reset, the pending, mask and force registers, the test bit, `irq_level` and `reg_err` are all 0.
- R11: `irq_level` is registered. It changes one clock edge after the pending, force, mask or test state that caused the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 16 | One-cycle request pulses, one line per level |
| ack_valid | input | 1 | Acknowledge strobe from the core |
| ack_level | input | 4 | Level being acknowledged |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 pending, 1 mask, 2 clear, 3 force, 4 test-control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register |
| irq_level | output | 4 | Registered highest active level, 0 for none |
| reg_err | output | 1 | One-cycle pulse after a write that sets reserved bits |

## Verification
The bench builds the block with its default parameters: 16 levels, a 32-bit data path, the test bit at position 19, the top level unmaskable, and the grouped priority encoder. With these values the exact error patterns 0xFFFF8001 and 0xFFFF0001 can be tested. So can the unmaskable level 15 and the switch of the acknowledge between force and pending as test mode changes. Same-cycle collisions between a request and a clear, or a request and an acknowledge, are driven directly, and the one-cycle lag of the request level is sampled on the edge where pending has just changed.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   typedef enum logic [2:0] {
      SEL_PEND  = 3'd0,
      SEL_MASK  = 3'd1,
      SEL_CLR   = 3'd2,
      SEL_FORCE = 3'd3,
      SEL_TEST  = 3'd4
   } reg_sel_e;

   localparam int ENC_LINEAR  = 0;
   localparam int ENC_GROUPED = 1;

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int NUM_LEVELS     = 16,
   parameter int LVL_W          = 4,
   parameter int DATA_W         = 32,
   parameter int TEST_BIT       = 19,
   parameter bit UNMASKABLE_TOP = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LEVELS-1:0] irq_req,
   input  logic                  ack_valid,
   input  logic [LVL_W-1:0]      ack_level,
   input  logic                  reg_wr,
   input  logic [2:0]            reg_sel,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   output logic [NUM_LEVELS-1:0] pend_q,
   output logic [NUM_LEVELS-1:0] mask_q,
   output logic [NUM_LEVELS-1:0] force_q,
   output logic                  test_on,
   output logic                  reg_err
);

   localparam int PAD_W = DATA_W - NUM_LEVELS;
   localparam logic TOP_MASKABLE = UNMASKABLE_TOP ? 1'b0 : 1'b1;
   localparam logic [NUM_LEVELS-1:0] LVL_VALID = {{(NUM_LEVELS-1){1'b1}}, 1'b0};
   localparam logic [NUM_LEVELS-1:0] LVL_MASKABLE =
      {TOP_MASKABLE, {(NUM_LEVELS-2){1'b1}}, 1'b0};
   localparam logic [DATA_W-1:0] MASK_OK = {{PAD_W{1'b0}}, LVL_MASKABLE};
   localparam logic [DATA_W-1:0] SRC_OK  = {{PAD_W{1'b0}}, LVL_VALID};

   logic wr_mask, wr_clr, wr_force, wr_test;
   logic [NUM_LEVELS-1:0] wlow;
   logic [NUM_LEVELS-1:0] ack_hit, ack_force, ack_pend;
   logic [NUM_LEVELS-1:0] clr_bits;
   logic [NUM_LEVELS-1:0] pend_d, mask_d, force_d;
   logic                  test_d, err_d;

   assign wr_mask  = reg_wr && (reg_sel == SEL_MASK);
   assign wr_clr   = reg_wr && (reg_sel == SEL_CLR);
   assign wr_force = reg_wr && (reg_sel == SEL_FORCE);
   assign wr_test  = reg_wr && (reg_sel == SEL_TEST);
   assign wlow     = reg_wdata[NUM_LEVELS-1:0];

   // one-hot decode of the acknowledged level; level 0 never matches
   assign ack_hit[0] = 1'b0;
   for (genvar i = 1; i < NUM_LEVELS; i++) begin : g_ack
      assign ack_hit[i] = ack_valid && (ack_level == LVL_W'(i));
   end

   assign ack_force = ack_hit & force_q & {NUM_LEVELS{test_on}};
   assign ack_pend  = ack_hit & ~ack_force;
   assign clr_bits  = wr_clr ? wlow : '0;

   always_comb begin
      // a new request in the same cycle outlives any clear
      pend_d  = ((pend_q & ~clr_bits & ~ack_pend) | irq_req) & LVL_VALID;
      mask_d  = wr_mask ? (wlow & LVL_MASKABLE) : mask_q;
      force_d = (wr_force && test_on) ? (wlow & LVL_VALID)
                                      : (force_q & ~ack_force);
      test_d  = wr_test ? reg_wdata[TEST_BIT] : test_on;
      err_d   = (wr_mask && ((reg_wdata & ~MASK_OK) != '0)) ||
                ((wr_clr || wr_force) && ((reg_wdata & ~SRC_OK) != '0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= '0;
         mask_q  <= '0;
         force_q <= '0;
         test_on <= 1'b0;
         reg_err <= 1'b0;
      end else begin
         pend_q  <= pend_d;
         mask_q  <= mask_d;
         force_q <= force_d;
         test_on <= test_d;
         reg_err <= err_d;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_sel)
         SEL_PEND:  reg_rdata = {{PAD_W{1'b0}}, pend_q};
         SEL_MASK:  reg_rdata = {{PAD_W{1'b0}}, mask_q};
         SEL_FORCE: reg_rdata = {{PAD_W{1'b0}}, force_q};
         SEL_TEST:  reg_rdata[TEST_BIT] = test_on;
         default:   reg_rdata = '0;
      endcase
   end

   // R1: unused bit 0 never holds state
   p_bit0_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q[0] && !force_q[0]);

   for (genvar i = 1; i < NUM_LEVELS; i++) begin : g_req_chk
      p_req_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
         irq_req[i] |=> pend_q[i]);
   end

   if (UNMASKABLE_TOP) begin : g_top_chk
      p_top_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !mask_q[NUM_LEVELS-1]);
   end

   p_force_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !test_on |=> $stable(force_q));

   p_ack_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_level != '0 && !irq_req[ack_level] &&
       !(test_on && force_q[ack_level])) |=> !pend_q[$past(ack_level)]);

   p_mask_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_MASK && (reg_wdata & ~MASK_OK) != '0)
      |=> reg_err);

   p_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> !reg_err);

endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc
   import irqc_pkg::*;
#(
   parameter int NUM_LEVELS = 16,
   parameter int LVL_W      = 4,
   parameter int ENC_STYLE  = ENC_GROUPED
) (
   input  logic [NUM_LEVELS-1:0] src,
   output logic [LVL_W-1:0]      idx
);

   localparam int GROUPS = NUM_LEVELS / 4;

   if (ENC_STYLE == ENC_LINEAR) begin : g_linear
      // later (higher) hits override earlier ones
      always_comb begin
         idx = '0;
         for (int k = 1; k < NUM_LEVELS; k++) begin
            if (src[k]) idx = LVL_W'(k);
         end
      end
   end else begin : g_grouped
      logic [GROUPS-1:0] grp_any;
      logic [1:0]        grp_idx [GROUPS];

      for (genvar g = 0; g < GROUPS; g++) begin : g_grp
         logic [3:0] nib;
         assign nib        = src[4*g +: 4];
         assign grp_any[g] = |nib;
         assign grp_idx[g] = nib[3] ? 2'd3 :
                             nib[2] ? 2'd2 :
                             nib[1] ? 2'd1 : 2'd0;
      end

      always_comb begin
         idx = '0;
         for (int g = 0; g < GROUPS; g++) begin
            if (grp_any[g]) idx = LVL_W'(4*g + int'(grp_idx[g]));
         end
      end
   end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int NUM_LEVELS     = 16,
   parameter int LVL_W          = $clog2(NUM_LEVELS),
   parameter int DATA_W         = 32,
   parameter int TEST_BIT       = 19,
   parameter bit UNMASKABLE_TOP = 1'b1,
   parameter int ENC_STYLE      = ENC_GROUPED
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LEVELS-1:0] irq_req,
   input  logic                  ack_valid,
   input  logic [LVL_W-1:0]      ack_level,
   input  logic                  reg_wr,
   input  logic [2:0]            reg_sel,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   output logic [LVL_W-1:0]      irq_level,
   output logic                  reg_err
);

   localparam logic [NUM_LEVELS-1:0] LVL_VALID = {{(NUM_LEVELS-1){1'b1}}, 1'b0};

   if (NUM_LEVELS < 8 || (NUM_LEVELS % 4) != 0) begin : g_bad_levels
      $error("NUM_LEVELS must be a multiple of 4 and at least 8");
   end
   if (LVL_W != $clog2(NUM_LEVELS)) begin : g_bad_lvlw
      $error("LVL_W must equal clog2(NUM_LEVELS)");
   end
   if (DATA_W <= NUM_LEVELS || TEST_BIT >= DATA_W) begin : g_bad_data
      $error("DATA_W must exceed NUM_LEVELS and hold TEST_BIT");
   end
   if (ENC_STYLE != ENC_LINEAR && ENC_STYLE != ENC_GROUPED) begin : g_bad_enc
      $error("ENC_STYLE selects an unknown encoder");
   end

   logic [NUM_LEVELS-1:0] pend_q, mask_q, force_q;
   logic                  test_on;
   logic [NUM_LEVELS-1:0] eff_src;
   logic [LVL_W-1:0]      enc_idx;

   irqc_regs #(
      .NUM_LEVELS     (NUM_LEVELS),
      .LVL_W          (LVL_W),
      .DATA_W         (DATA_W),
      .TEST_BIT       (TEST_BIT),
      .UNMASKABLE_TOP (UNMASKABLE_TOP)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_req   (irq_req),
      .ack_valid (ack_valid),
      .ack_level (ack_level),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pend_q    (pend_q),
      .mask_q    (mask_q),
      .force_q   (force_q),
      .test_on   (test_on),
      .reg_err   (reg_err)
   );

   assign eff_src = (pend_q | (test_on ? force_q : '0)) & ~mask_q & LVL_VALID;

   irqc_prio_enc #(
      .NUM_LEVELS (NUM_LEVELS),
      .LVL_W      (LVL_W),
      .ENC_STYLE  (ENC_STYLE)
   ) u_enc (
      .src (eff_src),
      .idx (enc_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_level <= '0;
      else        irq_level <= enc_idx;
   end

   // R3 and R11: output is the top bit of the source one edge earlier
   p_level_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(eff_src) >> irq_level) == NUM_LEVELS'(irq_level != '0));

   p_level_lag_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(eff_src) |=> $stable(irq_level));

endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;

   typedef struct {
      int          kind;   // 0 level, 1 error, 2 read data
      logic [31:0] exp;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_req = '0;
   logic        ack_valid = 1'b0;
   logic [3:0]  ack_level = '0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  irq_level;
   logic        reg_err;

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   done    = 1'b0;
   item_t sb_q[$];

   logic [15:0] m_pend = '0, m_mask = '0, m_frc = '0;
   logic        m_test = 1'b0;

   always #2.5 clk = ~clk;

   prio_irq_ctrl u_prio_irq_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_req   (irq_req),
      .ack_valid (ack_valid),
      .ack_level (ack_level),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_level (irq_level),
      .reg_err   (reg_err)
   );

   function automatic logic [3:0] model_level();
      logic [15:0] s;
      s = (m_pend | (m_test ? m_frc : 16'h0)) & ~m_mask & 16'hFFFE;
      for (int k = 15; k >= 1; k--) if (s[k]) return 4'(k);
      return 4'd0;
   endfunction

   task automatic push(int kind, logic [31:0] exp, string tag);
      item_t it;
      it.kind = kind; it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
   endtask

   // monitor: compare every queued expectation just after the next edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = (it.kind == 0) ? 32'(irq_level) :
                  (it.kind == 1) ? 32'(reg_err) : reg_rdata;
            n_tests++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic chk_level(string tag);
      push(0, 32'(model_level()), tag);
      @(negedge clk);
   endtask

   task automatic chk_read(logic [2:0] sel, logic [31:0] exp, string tag);
      reg_sel = sel;
      push(2, exp, tag);
      @(negedge clk);
   endtask

   task automatic pulse(int lvl, string tag);
      irq_req = 16'(1) << lvl;
      push(0, 32'(model_level()), tag);   // level still the old one
      @(negedge clk);
      irq_req = '0;
      m_pend = (m_pend | (16'(1) << lvl)) & 16'hFFFE;
   endtask

   task automatic wr(logic [2:0] sel, logic [31:0] d, bit exp_err, string tag);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      push(1, 32'(exp_err), tag);
      @(negedge clk);
      reg_wr = 1'b0;
      case (sel)
         3'd1: m_mask = d[15:0] & 16'h7FFE;
         3'd2: m_pend = m_pend & ~(d[15:0] & 16'hFFFE);
         3'd3: if (m_test) m_frc = d[15:0] & 16'hFFFE;
         3'd4: m_test = d[19];
         default: ;
      endcase
   endtask

   task automatic ack(int lvl);
      ack_valid = 1'b1; ack_level = 4'(lvl);
      @(negedge clk);
      ack_valid = 1'b0;
      if (lvl != 0) begin
         if (m_test && m_frc[lvl]) m_frc[lvl] = 1'b0;
         else m_pend[lvl] = 1'b0;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      push(0, 0, "R10 level");
      push(1, 0, "R10 err");
      chk_read(3'd0, 0, "R10 pending");
      chk_read(3'd1, 0, "R10 mask");
      chk_read(3'd3, 0, "R10 force");
      chk_read(3'd4, 0, "R10 test");

      // R1, R3, R11: requests and latency
      pulse(3, "R11 lag on 3");
      chk_level("R3 level 3");
      pulse(9, "R11 lag on 9");
      chk_level("R3 level 9");
      pulse(0, "R1 level 0 pulse");
      chk_read(3'd0, 32'h0208, "R1 pending");

      // R4: masking, level 15 unmaskable
      wr(3'd1, 32'h0200, 1'b0, "R8 clean mask");
      chk_level("R4 mask 9");
      wr(3'd1, 32'hFFFF, 1'b1, "R8 mask err");
      chk_read(3'd1, 32'h7FFE, "R4 mask stored");
      chk_level("R4 all masked");
      pulse(15, "R11 lag on 15");
      chk_level("R4 level 15 unmaskable");
      wr(3'd1, 32'h0, 1'b0, "R8 mask zero");
      chk_level("R3 back to 15");

      // R5: clear port
      wr(3'd2, 32'h8000, 1'b0, "R8 clean clear");
      chk_level("R5 cleared 15");
      wr(3'd2, 32'h0001, 1'b1, "R8 clear err");
      chk_read(3'd0, 32'h0208, "R5 pending kept");
      chk_read(3'd2, 0, "R5 clear reads 0");

      // R7: acknowledge in normal mode
      ack(9);
      chk_level("R7 ack 9");
      ack(0);
      chk_read(3'd0, 32'h0008, "R7 ack 0 ignored");
      ack(3);
      chk_level("R7 ack 3");

      // R6, R2: force register
      wr(3'd3, 32'h0020, 1'b0, "R8 force locked write");
      chk_read(3'd3, 0, "R6 force locked");
      chk_level("R6 no forced level");
      wr(3'd4, 32'h0008_0000, 1'b0, "R8 test write");
      chk_read(3'd4, 32'h0008_0000, "R2 test bit");
      wr(3'd3, 32'h0001_0021, 1'b1, "R8 force err");
      chk_read(3'd3, 32'h0020, "R6 force stored");
      chk_level("R2 forced level 5");
      pulse(5, "R11 lag on 5");
      ack(5);
      chk_read(3'd3, 0, "R7 force bit cleared");
      chk_read(3'd0, 32'h0020, "R7 pending kept");
      chk_level("R7 pending 5 still");
      ack(5);
      chk_level("R7 second ack");
      wr(3'd3, 32'h0040, 1'b0, "R8 force 6");
      wr(3'd4, 32'h0, 1'b0, "R8 test off");
      chk_level("R2 force ignored");
      chk_read(3'd3, 32'h0040, "R2 force kept");
      ack(6);
      chk_read(3'd3, 32'h0040, "R7 ack off-mode keeps force");
      wr(3'd4, 32'h0008_0000, 1'b0, "R8 test on");
      chk_level("R2 forced 6 again");

      // R9: same-cycle collisions
      reg_wr = 1'b1; reg_sel = 3'd3; reg_wdata = 32'h0040;
      ack_valid = 1'b1; ack_level = 4'd6;
      @(negedge clk);
      reg_wr = 1'b0; ack_valid = 1'b0;
      chk_read(3'd3, 32'h0040, "R9 force write wins");
      ack(6);
      wr(3'd4, 32'h0, 1'b0, "R8 test off 2");
      irq_req = 16'h0010; reg_wr = 1'b1; reg_sel = 3'd2; reg_wdata = 32'h0010;
      @(negedge clk);
      irq_req = '0; reg_wr = 1'b0;
      m_pend = m_pend | 16'h0010;
      chk_read(3'd0, 32'h0010, "R9 request beats clear");
      irq_req = 16'h0010; ack_valid = 1'b1; ack_level = 4'd4;
      @(negedge clk);
      irq_req = '0; ack_valid = 1'b0;
      chk_read(3'd0, 32'h0010, "R9 request beats ack");
      chk_level("R3 level 4");
      ack(4);
      chk_level("R7 final idle");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule